// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control state machine and program counter of a non-pipelined 32-bit RISC-V style core. The core has separate instruction and data RAMs, and each RAM returns read data one cycle after it accepts an address. The block walks each instruction through a fetch state and an execute state. Loads add a wait state and a writeback state to absorb the data RAM latency. The block also holds the core in execute while a multicycle multiply/divide unit works.

An external decoder supplies the instruction class, the destination register, a write flag and a control-flow target. The ALU supplies its result, which doubles as the data address. The sequencer drives the two memory request channels. It produces the single register-file write for each instruction and emits a one-cycle retire pulse when an instruction completes.

Both memory request channels follow the valid/ready rule. A request raises valid and keeps valid and its address and direction steady until the cycle in which ready is high. That cycle is the transfer. A memory applies back-pressure by keeping ready low, for any number of cycles, and the sequencer never assumes a fixed latency. Read data for an accepted instruction request is used in the following cycle. Read data for an accepted load is captured in the following cycle.

Top module: `cpu_seq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the fetch address is 0x2000_0000, fetch valid is high, and data valid, multiply start, register write and retire are all low.
- R2: In the fetch state, fetch valid stays high and the fetch address stays unchanged until fetch ready is seen. Decoded inputs presented during fetch cause no data request, no multiply start and no register write.
- R3: The class input is encoded 0 for ALU/control, 1 for multiply/divide, 2 for load and 3 for store. An ALU-class instruction retires in its first execute cycle with the ALU result as write data. With a ready fetch it takes exactly 2 cycles.
- R4: The PC changes only in a retire cycle. It then loads the redirect target if the class is ALU and redirect is high; otherwise it steps by 4. Redirect is ignored for the other classes.
- R5: A multiply/divide instruction raises the multiply start for exactly its first execute cycle. It then waits in execute until the done input is high (done is ignored in the start cycle). In the done cycle it writes the multiply result and retires.
- R6: A store raises data valid with write-enable high and the ALU result as address until data ready is seen. It retires in that acceptance cycle and never writes a register.
- R7: A load raises data valid with write-enable low until data ready is seen. In the next cycle it captures the data read value. In the cycle after that it writes the captured value and retires, for a minimum of 4 cycles per load.
- R8: A register write happens only in a retire cycle, at most once per instruction. It occurs only when the write flag is set and the destination index is non-zero.
- R9: Retire is a single-cycle pulse per instruction and is followed at once by a fetch cycle. Instruction and data requests are never valid together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_valid | output | 1 | Instruction fetch request |
| imem_addr | output | XLEN | Fetch address (current PC) |
| imem_ready | input | 1 | Instruction RAM accepts the fetch |
| cls | input | 2 | Decoded instruction class |
| wr_rd | input | 1 | Instruction writes its destination register |
| rd_idx | input | REG_AW | Destination register index |
| redirect | input | 1 | Branch taken or jump |
| redirect_pc | input | XLEN | Control-flow target |
| alu_result | input | XLEN | ALU result, also the data address |
| dmem_valid | output | 1 | Data request |
| dmem_we | output | 1 | Data request is a write |
| dmem_addr | output | XLEN | Data address |
| dmem_ready | input | 1 | Data RAM accepts the request |
| dmem_rdata | input | XLEN | Load data, valid the cycle after acceptance |
| md_start | output | 1 | One-cycle start to the multiply/divide unit |
| md_done | input | 1 | Multiply/divide result is available |
| md_result | input | XLEN | Multiply/divide result |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | REG_AW | Register-file write index |
| rf_wdata | output | XLEN | Register-file write data |
| retire | output | 1 | One-cycle pulse per completed instruction |

## Verification
Three events can coincide in one cycle: the data port's acceptance of a store, that instruction's retire pulse, and the PC update. The same holds for an ALU-class redirect, which retires and loads its target in its only execute cycle. The bench provokes the coincidence by holding data ready high before execute begins (zero-wait store) and by mixing redirects with random wait counts on both ports. It judges the result at the ports: retire must be high with no register write in the acceptance cycle, the next fetch must present the expected address, and the cycle count of each instruction must match the count derived from its waits.

// File: rtl/seqc_pkg.sv
package seqc_pkg;
  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_MWAIT = 2'd2,
    ST_WB    = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    CL_ALU = 2'd0,
    CL_MD  = 2'd1,
    CL_LD  = 2'd2,
    CL_ST  = 2'd3
  } instr_cls_e;

  typedef enum logic [1:0] {
    WB_ALU = 2'd0,
    WB_MD  = 2'd1,
    WB_LD  = 2'd2
  } wb_sel_e;

  typedef struct packed {
    logic    imem_valid;
    logic    dmem_valid;
    logic    dmem_we;
    logic    md_start;
    logic    retire;
    logic    wr_now;
    logic    ld_cap;
    logic    jump;
    wb_sel_e wb_sel;
  } seq_ctl_t;
endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
  import seqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cls,
  input  logic       redirect,
  input  logic       imem_ready,
  input  logic       dmem_ready,
  input  logic       md_done,
  output seq_ctl_t   ctl
);
  seq_state_e state, state_nx;
  logic       exec_first;
  instr_cls_e icls;

  assign icls = instr_cls_e'(cls);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_FETCH;
      exec_first <= 1'b0;
    end else begin
      state      <= state_nx;
      exec_first <= (state == ST_FETCH) && imem_ready;
    end
  end

  always_comb begin
    state_nx = state;
    ctl      = '0;
    ctl.wb_sel = WB_ALU;
    unique case (state)
      ST_FETCH: begin
        ctl.imem_valid = 1'b1;
        if (imem_ready) state_nx = ST_EXEC;
      end
      ST_EXEC: begin
        unique case (icls)
          CL_ALU: begin
            ctl.retire = 1'b1;
            ctl.wr_now = 1'b1;
            ctl.jump   = redirect;
            state_nx   = ST_FETCH;
          end
          CL_MD: begin
            ctl.md_start = exec_first;
            ctl.wb_sel   = WB_MD;
            if (!exec_first && md_done) begin
              ctl.retire = 1'b1;
              ctl.wr_now = 1'b1;
              state_nx   = ST_FETCH;
            end
          end
          CL_LD: begin
            ctl.dmem_valid = 1'b1;
            if (dmem_ready) state_nx = ST_MWAIT;
          end
          CL_ST: begin
            ctl.dmem_valid = 1'b1;
            ctl.dmem_we    = 1'b1;
            if (dmem_ready) begin
              ctl.retire = 1'b1;
              state_nx   = ST_FETCH;
            end
          end
          default: state_nx = ST_FETCH;
        endcase
      end
      ST_MWAIT: begin
        ctl.ld_cap = 1'b1;
        state_nx   = ST_WB;
      end
      ST_WB: begin
        ctl.retire = 1'b1;
        ctl.wr_now = 1'b1;
        ctl.wb_sel = WB_LD;
        state_nx   = ST_FETCH;
      end
      default: state_nx = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h2000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            advance,
  input  logic            jump,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc
);
  localparam int STEP = XLEN / 8 / ((XLEN == 64) ? 2 : 1);

  always_ff @(posedge clk) begin
    if (rst)          pc <= XLEN'(RESET_PC);
    else if (advance) pc <= jump ? target : pc + XLEN'(STEP);
  end
endmodule

// File: rtl/seq_wb.sv
module seq_wb
  import seqc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_cap,
  input  logic              wr_now,
  input  logic              wr_rd,
  input  wb_sel_e           sel,
  input  logic [REG_AW-1:0] rd_idx,
  input  logic [XLEN-1:0]   alu_result,
  input  logic [XLEN-1:0]   md_result,
  input  logic [XLEN-1:0]   dmem_rdata,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_waddr,
  output logic [XLEN-1:0]   rf_wdata
);
  logic [XLEN-1:0] ld_q;

  always_ff @(posedge clk) begin
    if (rst)         ld_q <= '0;
    else if (ld_cap) ld_q <= dmem_rdata;
  end

  assign rf_we    = wr_now && wr_rd && (rd_idx != '0);
  assign rf_waddr = rd_idx;

  always_comb begin
    unique case (sel)
      WB_MD:   rf_wdata = md_result;
      WB_LD:   rf_wdata = ld_q;
      default: rf_wdata = alu_result;
    endcase
  end
endmodule

// File: rtl/cpu_seq_ctrl.sv
module cpu_seq_ctrl
  import seqc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          REG_AW   = 5,
  parameter logic [31:0] RESET_PC = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst,
  output logic              imem_valid,
  output logic [XLEN-1:0]   imem_addr,
  input  logic              imem_ready,
  input  logic [1:0]        cls,
  input  logic              wr_rd,
  input  logic [REG_AW-1:0] rd_idx,
  input  logic              redirect,
  input  logic [XLEN-1:0]   redirect_pc,
  input  logic [XLEN-1:0]   alu_result,
  output logic              dmem_valid,
  output logic              dmem_we,
  output logic [XLEN-1:0]   dmem_addr,
  input  logic              dmem_ready,
  input  logic [XLEN-1:0]   dmem_rdata,
  output logic              md_start,
  input  logic              md_done,
  input  logic [XLEN-1:0]   md_result,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              retire
);
  seq_ctl_t ctl;

  seq_fsm u_fsm (
    .clk(clk), .rst(rst), .cls(cls), .redirect(redirect),
    .imem_ready(imem_ready), .dmem_ready(dmem_ready), .md_done(md_done),
    .ctl(ctl)
  );

  seq_pc #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst(rst), .advance(ctl.retire), .jump(ctl.jump),
    .target(redirect_pc), .pc(imem_addr)
  );

  seq_wb #(.XLEN(XLEN), .REG_AW(REG_AW)) u_wb (
    .clk(clk), .rst(rst), .ld_cap(ctl.ld_cap), .wr_now(ctl.wr_now),
    .wr_rd(wr_rd), .sel(ctl.wb_sel), .rd_idx(rd_idx),
    .alu_result(alu_result), .md_result(md_result), .dmem_rdata(dmem_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  assign imem_valid = ctl.imem_valid;
  assign dmem_valid = ctl.dmem_valid;
  assign dmem_we    = ctl.dmem_we;
  assign dmem_addr  = alu_result;
  assign md_start   = ctl.md_start;
  assign retire     = ctl.retire;
endmodule

// File: rtl/seq_ctrl_chk.sv
module seq_ctrl_chk #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              imem_valid,
  input logic              imem_ready,
  input logic [XLEN-1:0]   imem_addr,
  input logic              dmem_valid,
  input logic              dmem_ready,
  input logic              dmem_we,
  input logic              md_start,
  input logic              retire,
  input logic              rf_we,
  input logic [REG_AW-1:0] rf_waddr
);
  // R2
  fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    imem_valid && !imem_ready |=> imem_valid && $stable(imem_addr));
  // R4
  pc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !retire |=> $stable(imem_addr));
  // R5
  md_start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    md_start |=> !md_start);
  // R6
  dreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_valid && !dmem_ready |=> dmem_valid && $stable(dmem_we));
  // R8
  we_in_retire_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> retire);
  // R8
  no_x0_write_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> rf_waddr != '0);
  // R9
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(imem_valid && dmem_valid));
  // R9
  retire_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    retire |=> imem_valid && !retire);
endmodule

bind cpu_seq_ctrl seq_ctrl_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst(rst), .imem_valid(imem_valid), .imem_ready(imem_ready),
  .imem_addr(imem_addr), .dmem_valid(dmem_valid), .dmem_ready(dmem_ready),
  .dmem_we(dmem_we), .md_start(md_start), .retire(retire), .rf_we(rf_we),
  .rf_waddr(rf_waddr)
);

// File: tb/tb_cpu_seq_ctrl.sv
`timescale 1ns/1ps
module tb_cpu_seq_ctrl;
  logic        clk = 0;
  logic        rst;
  logic        imem_valid, imem_ready;
  logic [31:0] imem_addr;
  logic [1:0]  cls;
  logic        wr_rd, redirect;
  logic [4:0]  rd_idx;
  logic [31:0] redirect_pc, alu_result;
  logic        dmem_valid, dmem_we, dmem_ready;
  logic [31:0] dmem_addr, dmem_rdata;
  logic        md_start, md_done;
  logic [31:0] md_result;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        retire;

  int checks = 0, fails = 0, cyc = 0, rcnt = 0;
  bit done = 0;
  logic [31:0] exp_pc;

  always #2.5 clk = ~clk;

  cpu_seq_ctrl dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && retire) rcnt <= rcnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic garbage();
    cls = 2'($urandom); wr_rd = 1'($urandom); rd_idx = 5'($urandom);
    redirect = 1'($urandom); redirect_pc = $urandom; alu_result = $urandom;
    md_result = $urandom; dmem_rdata = $urandom;
    dmem_ready = 0; md_done = 0;
  endtask

  // Entered just after a negedge inside a fetch cycle.
  task automatic run_instr(input logic [1:0] c, input logic [4:0] rd, input logic wr,
                           input logic rdr, input logic [31:0] tgt, input logic [31:0] alu,
                           input int fw, input int mw, input int mdl,
                           input logic [31:0] ldat, input logic [31:0] mres);
    int start_cyc = cyc;
    int start_r = rcnt;
    int exp_cyc;
    logic expwe = wr && (rd != 0) && (c != 2'd3);
    for (int i = 0; i < fw; i++) begin
      garbage(); imem_ready = 0; #1;
      chk("R2 fetch valid", imem_valid, 1); chk("R2 fetch addr", imem_addr, exp_pc);
      chk("R2 no dreq", dmem_valid, 0); chk("R2 no start", md_start, 0);
      chk("R2 no write", rf_we, 0);
      @(negedge clk);
    end
    garbage(); imem_ready = 1; #1;
    chk("R4 fetch addr", imem_addr, exp_pc); chk("R2 fetch valid", imem_valid, 1);
    @(negedge clk);
    imem_ready = 0; cls = c; rd_idx = rd; wr_rd = wr; redirect = rdr;
    redirect_pc = tgt; alu_result = alu; md_done = 0; dmem_ready = (mw == 0);
    case (c)
      2'd0: begin
        #1; chk("R3 retire", retire, 1); chk("R8 we", rf_we, expwe);
        chk("R3 wdata", rf_wdata, alu); chk("R9 no fetch", imem_valid, 0);
        @(negedge clk); exp_cyc = fw + 2;
      end
      2'd1: begin
        #1; chk("R5 start", md_start, 1); chk("R5 no retire", retire, 0);
        @(negedge clk);
        for (int i = 0; i < mdl - 1; i++) begin
          #1; chk("R5 start low", md_start, 0); chk("R5 wait", retire, 0);
          chk("R8 no early we", rf_we, 0);
          @(negedge clk);
        end
        md_done = 1; md_result = mres; #1;
        chk("R5 retire", retire, 1); chk("R8 we", rf_we, expwe);
        chk("R5 wdata", rf_wdata, mres);
        @(negedge clk); md_done = 0; exp_cyc = fw + 2 + mdl;
      end
      default: begin
        for (int i = 0; i < mw; i++) begin
          #1; chk(c == 2'd3 ? "R6 valid" : "R7 valid", dmem_valid, 1);
          chk(c == 2'd3 ? "R6 we" : "R7 rd", dmem_we, (c == 2'd3));
          chk("R6 addr", dmem_addr, alu); chk("R6 no retire", retire, 0);
          @(negedge clk); dmem_ready = (i == mw - 1);
        end
        #1; chk("R6 valid", dmem_valid, 1); chk("R6 addr", dmem_addr, alu);
        if (c == 2'd3) begin
          chk("R6 retire", retire, 1); chk("R6 no write", rf_we, 0);
          @(negedge clk); exp_cyc = fw + mw + 2;
        end else begin
          chk("R7 no retire", retire, 0);
          @(negedge clk); dmem_ready = 0; dmem_rdata = ldat; #1;
          chk("R7 wait idle", dmem_valid, 0); chk("R7 wait no retire", retire, 0);
          chk("R8 wait no we", rf_we, 0);
          @(negedge clk); dmem_rdata = ~ldat; #1;
          chk("R7 retire", retire, 1); chk("R8 we", rf_we, expwe);
          chk("R7 wdata", rf_wdata, ldat);
          @(negedge clk); exp_cyc = fw + mw + 4;
        end
      end
    endcase
    chk("R9 cycles", cyc - start_cyc, exp_cyc);
    chk("R9 one retire", rcnt - start_r, 1);
    exp_pc = (c == 2'd0 && rdr) ? tgt : exp_pc + 4;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=finished", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC0_0042));
    rst = 1; imem_ready = 0; garbage();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset pc", imem_addr, 32'h2000_0000); chk("R1 fetch", imem_valid, 1);
    chk("R1 no retire", retire, 0); chk("R1 no we", rf_we, 0);
    rst = 0; exp_pc = 32'h2000_0000;
    @(negedge clk); #1;
    chk("R1 pc after", imem_addr, 32'h2000_0000); chk("R1 dvalid", dmem_valid, 0);
    chk("R1 start", md_start, 0);
    // directed corners
    run_instr(2'd0, 5'd3, 1, 0, 0, 32'h1111_0000, 0, 0, 1, 0, 0);                // R3
    run_instr(2'd0, 5'd0, 1, 0, 0, 32'hDEAD_BEEF, 2, 0, 1, 0, 0);                // R8 x0
    run_instr(2'd0, 5'd5, 1, 1, 32'h2000_0100, 32'h7, 0, 0, 1, 0, 0);            // R4 jump
    run_instr(2'd3, 5'd6, 1, 1, 32'h2000_F000, 32'h8000_0010, 0, 0, 1, 0, 0);    // R6 zero-wait, R4 ignored
    run_instr(2'd3, 5'd6, 1, 0, 0, 32'h8000_0020, 1, 3, 1, 0, 0);                // R6 waits
    run_instr(2'd2, 5'd7, 1, 0, 0, 32'h8000_0030, 0, 0, 1, 32'hCAFE_F00D, 0);    // R7 min
    run_instr(2'd2, 5'd0, 1, 0, 0, 32'h8000_0034, 0, 2, 1, 32'h1234_5678, 0);    // R7 x0
    run_instr(2'd1, 5'd9, 1, 1, 32'h2000_0800, 0, 0, 0, 1, 0, 32'hABCD_0001);    // R5 fast
    run_instr(2'd1, 5'd10, 1, 0, 0, 0, 0, 0, 33, 0, 32'h0F0F_0F0F);              // R5 divide
    run_instr(2'd0, 5'd11, 0, 1, 32'h2000_0004, 32'h5, 0, 0, 1, 0, 0);           // branch, no write
    for (int n = 0; n < 300; n++) begin
      run_instr(2'($urandom), 5'($urandom), 1'($urandom), 1'($urandom),
                {16'h2000, 16'($urandom) & 16'hFFFC}, $urandom,
                $urandom % 3, $urandom % 3, 1 + $urandom % 6, $urandom, $urandom);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule